// File: doc/BRIEF.md
# Message-Store Write Combining Line

This block gathers stores marked with the message memory type into a single 32-byte line. It then sends that line to memory as one bus write. It sits between a core's store path and the memory bus. The core offers one store at a time: a physical byte address, up to four bytes of data, a per-byte mask and a two-bit memory kind. Tagged stores that stay inside the line already held are merged in place and cause no bus traffic.

The line leaves the block in two cases. The first is a tagged store to a different line. The second is an explicit flush request, which stands for a fence or a dummy write. Stores of any other kind, cacheable or uncached, pass by and never disturb the buffer. A partly filled line can therefore wait indefinitely. The outgoing write always carries the whole line. Per-byte strobes and per-word enables mark the valid parts, and a flag tells a full burst from a partial write.

Top module: `wc_line_buffer`

## Requirements
- R1: After reset the bus side is idle (`bus_valid` low), `st_ready` is high and the buffer is empty, so a flush request right after reset produces no bus write.
- R2: A store of kind 2'b10 (message type) whose line address equals the held line is merged into the buffer and causes no bus write.
- R3: A message-type store to a different line, while the buffer holds at least one valid byte, raises `bus_valid` on the next cycle with the old line's address and contents. The incoming store becomes the only content of the new line.
- R4: Stores of kind 2'b00 (cacheable) or 2'b01 (uncached) never cause a bus write and never change the buffered line, whatever their address.
- R5: The bus write carries all 32 bytes. `bus_strb[k]` is set exactly for the valid bytes, and bytes not valid are driven as zero. `bus_wen[i]` is the OR of strobe bits 4i..4i+3.
- R6: `bus_full` is high exactly when all 32 strobe bits of the write are set.
- R7: A flush request accepted while the buffer is non-empty drains the line on the next cycle and leaves the buffer empty. A flush request with an empty buffer is ignored.
- R8: While `bus_valid` is high and `bus_ready` is low, `st_ready` is low and the bus outputs hold their values. A store or flush is taken only in a cycle with `st_ready` high.
- R9: A later message-type store to a byte that is already valid overwrites it, so the last store wins.
- R10: A flush and a message-type store accepted in the same cycle first send the current line. The store then starts a fresh line, even when it targets the same line.
- R11: Address bits [4:2] select the word lane, mask bit j selects byte j of that word, and bits [ADDR_W-1:5] form the line address placed on `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core store offered |
| st_ready | output | 1 | Store or flush can be taken this cycle |
| st_addr | input | ADDR_W | Physical byte address of the store |
| st_data | input | 32 | Store data, byte j in bits 8j+7:8j |
| st_mask | input | 4 | Byte mask within the addressed word |
| st_kind | input | 2 | Memory kind: 00 cacheable, 01 uncached, 10 message |
| flush_req | input | 1 | Drain request (fence or dummy write) |
| bus_valid | output | 1 | Line write pending |
| bus_ready | input | 1 | Bus accepts the line write |
| bus_addr | output | ADDR_W-5 | Line address of the write |
| bus_data | output | 256 | Line data |
| bus_strb | output | 32 | Per-byte valid strobes |
| bus_wen | output | 8 | Per-word enables |
| bus_full | output | 1 | Whole line valid (burst) |

## Verification
The hardest case to reach is a line eviction that lands while the previous write is still stalled on the bus. In that case the block must refuse the store, hold the outgoing line steady, and then take the store in the same cycle the bus drains. The stimulus holds `bus_ready` low across a forced eviction and keeps a store offered for several stalled cycles before releasing it. A long random phase then mixes message, cacheable and uncached stores over a few nearby lines with random flushes and a random `bus_ready`. A behavioural byte-array model is compared with the outputs every cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    typedef enum logic [1:0] {
        KIND_CACHED   = 2'b00,
        KIND_UNCACHED = 2'b01,
        KIND_MSG      = 2'b10,
        KIND_RSVD     = 2'b11
    } st_kind_e;
endpackage

// File: rtl/wcb_merge.sv
// Writes one masked word into a line image and updates byte-valid bits.
module wcb_merge #(
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [LINE_BYTES*8-1:0]                    base_data,
    input  logic [LINE_BYTES-1:0]                      base_vld,
    input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0]   wsel,
    input  logic [WORD_BYTES*8-1:0]                    wdata,
    input  logic [WORD_BYTES-1:0]                      wmask,
    output logic [LINE_BYTES*8-1:0]                    new_data,
    output logic [LINE_BYTES-1:0]                      new_vld
);
    localparam int WORDS = LINE_BYTES / WORD_BYTES;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
            localparam int K = w * WORD_BYTES + b;
            logic hit;
            assign hit = (wsel == w[$clog2(WORDS)-1:0]) && wmask[b];
            assign new_data[K*8 +: 8] = hit ? wdata[b*8 +: 8] : base_data[K*8 +: 8];
            assign new_vld[K]         = hit | base_vld[K];
        end
    end
endmodule

// File: rtl/wcb_lane_en.sv
// Reduces per-byte strobes to per-word enables.
module wcb_lane_en #(
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [LINE_BYTES-1:0]            strb,
    output logic [LINE_BYTES/WORD_BYTES-1:0] wen
);
    localparam int WORDS = LINE_BYTES / WORD_BYTES;

    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        assign wen[w] = |strb[w*WORD_BYTES +: WORD_BYTES];
    end
endmodule

// File: rtl/wc_line_buffer.sv
module wc_line_buffer
    import wcb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              st_valid,
    output logic                              st_ready,
    input  logic [ADDR_W-1:0]                 st_addr,
    input  logic [WORD_BYTES*8-1:0]           st_data,
    input  logic [WORD_BYTES-1:0]             st_mask,
    input  logic [1:0]                        st_kind,
    input  logic                              flush_req,
    output logic                              bus_valid,
    input  logic                              bus_ready,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] bus_addr,
    output logic [LINE_BYTES*8-1:0]           bus_data,
    output logic [LINE_BYTES-1:0]             bus_strb,
    output logic [LINE_BYTES/WORD_BYTES-1:0]  bus_wen,
    output logic                              bus_full
);
    localparam int WORDS  = LINE_BYTES / WORD_BYTES;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WB_W   = $clog2(WORD_BYTES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;

    typedef struct packed {
        logic [LA_W-1:0]       line;
        logic [LINE_BYTES-1:0] vld;
        logic [LINE_W-1:0]     data;
        logic                  ov;
        logic [LA_W-1:0]       oaddr;
        logic [LINE_W-1:0]     odata;
        logic [LINE_BYTES-1:0] ostrb;
    } state_t;

    state_t q, d;

    logic                  tag_take, flush_take, nonempty, same_line, evict;
    logic [LA_W-1:0]       st_line;
    logic [WSEL_W-1:0]     st_wsel;
    logic [LINE_W-1:0]     base_data, mrg_data;
    logic [LINE_BYTES-1:0] base_vld, mrg_vld;

    assign st_ready   = !q.ov || bus_ready;
    assign st_line    = st_addr[ADDR_W-1:OFF_W];
    assign st_wsel    = st_addr[OFF_W-1:WB_W];
    assign tag_take   = st_valid && st_ready && (st_kind_e'(st_kind) == KIND_MSG);
    assign flush_take = flush_req && st_ready;
    assign nonempty   = |q.vld;
    assign same_line  = (st_line == q.line);
    assign evict      = nonempty && (flush_take || (tag_take && !same_line));
    assign base_data  = evict ? '0 : q.data;
    assign base_vld   = evict ? '0 : q.vld;

    wcb_merge #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_merge (
        .base_data (base_data),
        .base_vld  (base_vld),
        .wsel      (st_wsel),
        .wdata     (st_data),
        .wmask     (st_mask),
        .new_data  (mrg_data),
        .new_vld   (mrg_vld)
    );

    always_comb begin
        d = q;
        if (q.ov && bus_ready) begin
            d.ov = 1'b0;
        end
        if (evict) begin
            d.ov    = 1'b1;
            d.oaddr = q.line;
            d.odata = q.data;
            d.ostrb = q.vld;
        end
        if (tag_take) begin
            d.line = st_line;
            d.data = mrg_data;
            d.vld  = mrg_vld;
        end else if (evict) begin
            d.data = '0;
            d.vld  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_valid = q.ov;
    assign bus_addr  = q.oaddr;
    assign bus_data  = q.odata;
    assign bus_strb  = q.ostrb;
    assign bus_full  = &q.ostrb;

    wcb_lane_en #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_lane (
        .strb (q.ostrb),
        .wen  (bus_wen)
    );

    // R8: a stalled write blocks the core side
    p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |-> !st_ready);

    // R8: a stalled write holds steady
    p_hold_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_data) && $stable(bus_strb)));

    // R7: only non-empty lines are ever sent
    p_never_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (|bus_strb));

    // R6: a burst has every word lane enabled
    p_full_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_full) |-> (&bus_wen));

    // R4: with no message store and no flush, an idle bus stays idle
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !flush_req && !(st_valid && st_kind == 2'b10)) |=> !bus_valid);
endmodule

// File: tb/tb_wc_line_buffer.sv
module tb_wc_line_buffer;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         st_valid, st_ready;
    logic [31:0]  st_addr, st_data;
    logic [3:0]   st_mask;
    logic [1:0]   st_kind;
    logic         flush_req, bus_valid, bus_ready, bus_full;
    logic [26:0]  bus_addr;
    logic [255:0] bus_data;
    logic [31:0]  bus_strb;
    logic [7:0]   bus_wen;

    int total = 0;
    int bad   = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    wc_line_buffer dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask), .st_kind(st_kind),
        .flush_req(flush_req), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_strb(bus_strb),
        .bus_wen(bus_wen), .bus_full(bus_full)
    );

    // behavioural reference: byte arrays
    logic [26:0] m_line;
    logic [7:0]  m_data [32];
    bit          m_vld  [32];
    bit          m_ov;
    logic [26:0] m_oaddr;
    logic [7:0]  m_odata [32];
    bit          m_ostrb [32];

    task automatic m_clear();
        m_line = '0; m_ov = 0; m_oaddr = '0;
        for (int k = 0; k < 32; k++) begin
            m_data[k] = 0; m_vld[k] = 0; m_odata[k] = 0; m_ostrb[k] = 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clear();
        end else begin
            bit rdy, tag, fl, ne, ev;
            rdy = !m_ov || bus_ready;
            tag = st_valid && rdy && st_kind == 2'b10;
            fl  = flush_req && rdy;
            ne  = 0;
            for (int k = 0; k < 32; k++) if (m_vld[k]) ne = 1;
            ev  = ne && (fl || (tag && st_addr[31:5] != m_line));
            if (m_ov && bus_ready) m_ov = 0;
            if (ev) begin
                m_ov = 1; m_oaddr = m_line;
                for (int k = 0; k < 32; k++) begin
                    m_odata[k] = m_data[k]; m_ostrb[k] = m_vld[k];
                    m_data[k] = 0; m_vld[k] = 0;
                end
            end
            if (tag) begin
                m_line = st_addr[31:5];
                for (int j = 0; j < 4; j++)
                    if (st_mask[j]) begin
                        m_data[st_addr[4:2]*4 + j] = st_data[j*8 +: 8];
                        m_vld[st_addr[4:2]*4 + j]  = 1;
                    end
            end
        end
    end

    task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [255:0] ed;
            logic [31:0]  es;
            logic [7:0]   ew;
            for (int k = 0; k < 32; k++) begin
                ed[k*8 +: 8] = m_odata[k];
                es[k] = m_ostrb[k];
            end
            for (int w = 0; w < 8; w++) ew[w] = |es[w*4 +: 4];
            chk("R8", "st_ready", st_ready, !m_ov || bus_ready);
            chk(phase, "bus_valid", bus_valid, m_ov);
            if (m_ov) begin
                chk("R11", "bus_addr", bus_addr, m_oaddr);
                chk("R5", "bus_data", bus_data, ed);
                chk("R5", "bus_strb", bus_strb, es);
                chk("R5", "bus_wen", bus_wen, ew);
                chk("R6", "bus_full", bus_full, &es);
            end
        end
    end

    task automatic put(logic [31:0] a, logic [31:0] dt, logic [3:0] m, logic [1:0] k, bit fl = 0);
        bit r;
        st_valid = 1; st_addr = a; st_data = dt; st_mask = m; st_kind = k; flush_req = fl;
        forever begin
            @(negedge clk); r = st_ready;
            @(posedge clk); #2;
            if (r) break;
        end
        st_valid = 0; flush_req = 0;
    endtask

    task automatic flush();
        bit r;
        flush_req = 1;
        forever begin
            @(negedge clk); r = st_ready;
            @(posedge clk); #2;
            if (r) break;
        end
        flush_req = 0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst_n = 0; st_valid = 0; st_addr = 0; st_data = 0; st_mask = 0;
        st_kind = 0; flush_req = 0; bus_ready = 1;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "reset bus_valid", bus_valid, 0);
        chk("R1", "reset st_ready", st_ready, 1);
        rst_n = 1;
        flush(); idle(1);
        chk("R1", "flush on empty", bus_valid, 0);

        phase = "R2";
        put(32'h1000, 32'h11223344, 4'hF, 2'b10);
        put(32'h1004, 32'h55667788, 4'hF, 2'b10);
        put(32'h100C, 32'h99AABBCC, 4'hF, 2'b10);
        chk("R2", "merge no bus", bus_valid, 0);

        phase = "R4";
        put(32'h1000, 32'hDEADBEEF, 4'hF, 2'b00);
        put(32'h1008, 32'hDEADBEEF, 4'h1, 2'b01);
        put(32'h2000, 32'hDEADBEEF, 4'hF, 2'b00);
        put(32'h7004, 32'hDEADBEEF, 4'hF, 2'b01);
        idle(2);
        chk("R4", "untagged no flush", bus_valid, 0);

        phase = "R3";
        put(32'h1100, 32'h000000A5, 4'h1, 2'b10);
        chk("R3", "evict valid", bus_valid, 1);
        chk("R11", "evict addr", bus_addr, 27'h80);
        chk("R5", "evict strb", bus_strb, 32'h0000F0FF);
        chk("R5", "evict wen", bus_wen, 8'b0000_1011);
        chk("R6", "partial flag", bus_full, 0);
        chk("R4", "untagged left data", bus_data[31:0], 32'h11223344);
        idle(1);

        phase = "R9";
        put(32'h1100, 32'h000000BB, 4'h1, 2'b10);
        phase = "R7";
        flush();
        chk("R9", "last store wins", bus_data[7:0], 8'hBB);
        chk("R7", "flush sends", bus_valid, 1);
        idle(1);
        flush(); idle(1);
        chk("R7", "buffer empty after drain", bus_valid, 0);

        phase = "R6";
        for (int w = 0; w < 8; w++) put(32'h3000 + w*4, 32'h01010101 * (w + 1), 4'hF, 2'b10);
        flush();
        chk("R6", "full burst", bus_full, 1);
        idle(1);

        phase = "R8";
        put(32'h4000, 32'hCAFEF00D, 4'h3, 2'b10);
        bus_ready = 0;
        put(32'h5000, 32'h12345678, 4'hF, 2'b10);
        st_valid = 1; st_addr = 32'h6000; st_data = 32'h0BADCAFE; st_mask = 4'hF; st_kind = 2'b10;
        idle(4);
        chk("R8", "stall holds", bus_addr, 27'h200);
        bus_ready = 1;
        idle(1);
        st_valid = 0;
        idle(2);

        phase = "R10";
        put(32'h6004, 32'h77777777, 4'hF, 2'b10, 1);
        chk("R10", "flush+store sends old", bus_addr, 27'h300);
        idle(1);
        phase = "R11";
        put(32'h801C, 32'hEE000000, 4'h8, 2'b10);
        flush();
        chk("R11", "top byte strobe", bus_strb, 32'h80000000);
        idle(1);

        phase = "R3";
        for (int i = 0; i < 3000; i++) begin
            st_valid  = ($urandom_range(0, 3) != 0);
            st_addr   = 32'h9000 + ($urandom_range(0, 2) << 5) + ($urandom_range(0, 7) << 2);
            st_data   = $urandom;
            st_mask   = 4'($urandom_range(1, 15));
            st_kind   = 2'($urandom_range(0, 2));
            flush_req = ($urandom_range(0, 15) == 0);
            bus_ready = ($urandom_range(0, 2) != 0);
            idle(1);
        end
        st_valid = 0; flush_req = 0; bus_ready = 1;
        idle(3);
        summary();
    end
endmodule